// File: doc/BRIEF.md
# Accelerator command stream parser

The parser sits between a command fetch path and the compute and transfer engines of an accelerator. It takes 32-bit words over a valid/ready input, splits each command into a header and, if the header asks for it, one payload word. Configuration commands land in one of two register banks: one holds the settings of the compute engine and the other those of the transfer (DMA) engine. Start commands leave the block as a one-cycle pulse that carries the opcode and the parameter. Each start also raises an outstanding-job count, and the matching done pulse from the engine lowers it again.

Wait commands hold off the stream until the chosen outstanding count has dropped to a requested level. This is how a command sequence orders a compute job behind the transfer that feeds it. A stop command ends parsing. A malformed header, an unknown opcode, or a stream that grows past the length limit ends parsing with a sticky error. The error records its cause and the byte offset of the command that caused it. The engines read the two banks through a read port.

Top module: `cmdp_parser`

## Requirements
- R1: A header word carries its code in bits 15:0 and a 16-bit parameter in bits 31:16. Code bits 15:14 give the length: 00 is a one-word command and 01 means one payload word follows. The opcode is code bits 9:0, and the one-word and two-word forms decode it separately.
- R2: A one-word command with opcode 0x100+i writes compute register i, and opcode 0x180+i writes transfer register i (i < NREG). The value is the parameter, zero-extended to 48 bits. A write to one bank leaves the other bank unchanged.
- R3: A two-word command with opcode 0x100+i or 0x180+i writes {parameter, payload} as a 48-bit value into compute or transfer register i. The header does not stall the input, so the payload can be taken in the next cycle.
- R4: Opcode 0x001 (compute start) and opcode 0x002 (transfer start, parameter = 16×channel+mode) each give op_valid for one cycle, in the cycle after the header is accepted. op_xfer is 0 for a compute start and 1 for a transfer start, and op_code and op_param carry the opcode and parameter. The matching pending count rises by one at the same time.
- R5: Each done pulse lowers its pending count by one. The count never goes below zero. A start and a done for the same engine in the same cycle leave the count unchanged.
- R6: Opcode 0x003 waits on the compute count and opcode 0x004 waits on the transfer count. The level is parameter bits 3:0, and the channel bits above them are ignored. in_ready is low from the cycle after the wait is accepted. It rises one cycle after the selected count is at or below the level, and the other count has no effect.
- R7: Opcode 0x000 with parameter 0xFFFF raises done and keeps in_ready low until reset. Words offered after it change no register.
- R8: A length field of 10 or 11 sets err with err_kind 1 and stops parsing (in_ready low). err_off holds the byte offset of that header. err, err_kind and err_off hold until reset.
- R9: An unknown opcode sets err with err_kind 2. This covers opcode 0x000 with any parameter other than 0xFFFF, a register index at or above NREG, and any two-word opcode outside the register ranges.
- R10: A word whose last byte would reach offset 2^LEN_LOG2 is dropped. It sets err with err_kind 3, and err_off holds the byte offset of the command it belongs to.
- R11: After reset in_ready is 1, done, err and op_valid are 0, both pending counts are 0 and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Word accepted when high with in_valid |
| run_done | input | 1 | Compute job finished |
| xfer_done | input | 1 | Transfer job finished |
| op_valid | output | 1 | Start pulse |
| op_xfer | output | 1 | Start targets the transfer engine |
| op_code | output | 10 | Opcode of the start |
| op_param | output | 16 | Parameter of the start |
| run_pending | output | CNT_W | Outstanding compute jobs |
| xfer_pending | output | CNT_W | Outstanding transfer jobs |
| rd_xfer | input | 1 | Read port bank select |
| rd_idx | input | IDX_W | Read port register index |
| rd_data | output | 48 | Read port data |
| done | output | 1 | Stop command reached |
| err | output | 1 | Parsing stopped on an error |
| err_kind | output | 2 | 1 bad length field, 2 unknown opcode, 3 length limit |
| err_off | output | LEN_LOG2 | Byte offset of the offending command |

## Verification
The length-limit error is the hardest case to reach, because it needs a stream close to 2^LEN_LOG2 bytes long. The bench builds the parser with a small limit and fills the stream with register writes to a single register. It places the final header so that the limit is hit once on a one-word command and once on the payload of a two-word command. A wait that stalls and then releases is also hard to reach, because the pending counts can only be moved through start commands and done pulses. The bench first loads the counts with starts, then pulses the done inputs while a wait is holding, and checks the cycle in which in_ready rises.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
    localparam int WORD_W  = 32;
    localparam int PARAM_W = 16;
    localparam int OPC_W   = 10;
    localparam int REG_W   = 48;

    localparam logic [1:0] MODE_SHORT = 2'b00;
    localparam logic [1:0] MODE_LONG  = 2'b01;

    localparam logic [OPC_W-1:0] OPC_STOP      = 10'h000;
    localparam logic [OPC_W-1:0] OPC_RUN       = 10'h001;
    localparam logic [OPC_W-1:0] OPC_XFER      = 10'h002;
    localparam logic [OPC_W-1:0] OPC_WAIT_RUN  = 10'h003;
    localparam logic [OPC_W-1:0] OPC_WAIT_XFER = 10'h004;
    localparam logic [PARAM_W-1:0] STOP_PARAM  = 16'hFFFF;

    typedef enum logic [3:0] {
        K_STOP, K_RUN, K_XFER, K_WAIT_RUN, K_WAIT_XFER,
        K_CFG_SHORT, K_CFG_LONG, K_BAD_MODE, K_BAD_OPC
    } kind_e;

    typedef enum logic [1:0] {
        ERR_NONE = 2'd0, ERR_MODE = 2'd1, ERR_OPC = 2'd2, ERR_LEN = 2'd3
    } err_e;

    typedef enum logic [2:0] {
        ST_HDR, ST_PAY, ST_WAIT, ST_STOP, ST_ERR
    } st_e;
endpackage

// File: rtl/cmdp_hdr_decode.sv
module cmdp_hdr_decode
    import cmdp_pkg::*;
#(
    parameter int NREG = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic [WORD_W-1:0] hdr,
    output kind_e             kind,
    output logic              xfer_bank,
    output logic [IDX_W-1:0]  slot
);
    logic [1:0]         mode;
    logic [OPC_W-1:0]   opc;
    logic [PARAM_W-1:0] prm;
    logic               cfg_hit;

    always_comb begin
        mode      = hdr[15:14];
        opc       = hdr[OPC_W-1:0];
        prm       = hdr[31:16];
        // 0x100..0x1FF: bit 7 picks the bank, bits 6:0 the register
        cfg_hit   = (opc[9:8] == 2'b01) && (int'(opc[6:0]) < NREG);
        xfer_bank = opc[7];
        slot      = opc[IDX_W-1:0];
        kind      = K_BAD_OPC;
        if (mode == MODE_LONG) begin
            if (cfg_hit) kind = K_CFG_LONG;
        end else if (mode == MODE_SHORT) begin
            if (cfg_hit) begin
                kind = K_CFG_SHORT;
            end else begin
                case (opc)
                    OPC_STOP:      if (prm == STOP_PARAM) kind = K_STOP;
                    OPC_RUN:       kind = K_RUN;
                    OPC_XFER:      kind = K_XFER;
                    OPC_WAIT_RUN:  kind = K_WAIT_RUN;
                    OPC_WAIT_XFER: kind = K_WAIT_XFER;
                    default:       kind = K_BAD_OPC;
                endcase
            end
        end else begin
            kind = K_BAD_MODE;
        end
    end
endmodule

// File: rtl/cmdp_job_counter.sv
module cmdp_job_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec) begin
            if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
        end else if (dec && !inc) begin
            if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/cmdp_cfg_bank.sv
module cmdp_cfg_bank #(
    parameter int NREG  = 8,
    parameter int REG_W = 48,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [REG_W-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [REG_W-1:0] rdata
);
    logic [REG_W-1:0] mem_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    assign rdata = mem_q[ridx];
endmodule

// File: rtl/cmdp_parser.sv
module cmdp_parser
    import cmdp_pkg::*;
#(
    parameter int NREG     = 8,
    parameter int CNT_W    = 4,
    parameter int LEN_LOG2 = 24,
    localparam int IDX_W   = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [31:0]         in_data,
    output logic                in_ready,
    input  logic                run_done,
    input  logic                xfer_done,
    output logic                op_valid,
    output logic                op_xfer,
    output logic [9:0]          op_code,
    output logic [15:0]         op_param,
    output logic [CNT_W-1:0]    run_pending,
    output logic [CNT_W-1:0]    xfer_pending,
    input  logic                rd_xfer,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [47:0]         rd_data,
    output logic                done,
    output logic                err,
    output logic [1:0]          err_kind,
    output logic [LEN_LOG2-1:0] err_off
);
    localparam int LVL_W = 4;  // wait level field below the channel bits

    typedef struct packed {
        st_e                 st;
        logic [PARAM_W-1:0]  hdr_prm;
        logic                hdr_xfer;
        logic [IDX_W-1:0]    hdr_slot;
        logic [LEN_LOG2-1:0] hdr_off;
        logic [LEN_LOG2-1:0] off;
        logic                wait_xfer;
        logic [LVL_W-1:0]    wait_lvl;
        logic                op_valid;
        logic                op_xfer;
        logic [OPC_W-1:0]    op_code;
        logic [PARAM_W-1:0]  op_param;
        err_e                err_kind;
        logic [LEN_LOG2-1:0] err_off;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    kind_e            dec_kind;
    logic             dec_xfer;
    logic [IDX_W-1:0] dec_slot;

    logic             wr_en, wr_xfer;
    logic [IDX_W-1:0] wr_idx;
    logic [REG_W-1:0] wr_data;
    logic             run_inc, xfer_inc;
    logic [CNT_W-1:0] run_cnt, xfer_cnt;
    logic             at_limit, wait_met, hdr_phase;
    logic [REG_W-1:0] bank_rd [2];

    cmdp_hdr_decode #(.NREG(NREG)) i_dec (
        .hdr       (in_data),
        .kind      (dec_kind),
        .xfer_bank (dec_xfer),
        .slot      (dec_slot)
    );

    cmdp_job_counter #(.CNT_W(CNT_W)) i_run_cnt (
        .clk, .rst_n, .inc(run_inc), .dec(run_done), .count(run_cnt)
    );

    cmdp_job_counter #(.CNT_W(CNT_W)) i_xfer_cnt (
        .clk, .rst_n, .inc(xfer_inc), .dec(xfer_done), .count(xfer_cnt)
    );

    for (genvar gb = 0; gb < 2; gb++) begin : g_bank
        cmdp_cfg_bank #(.NREG(NREG), .REG_W(REG_W)) i_bank (
            .clk, .rst_n,
            .we    (wr_en && (wr_xfer == (gb == 1))),
            .widx  (wr_idx),
            .wdata (wr_data),
            .ridx  (rd_idx),
            .rdata (bank_rd[gb])
        );
    end

    always_comb begin
        hdr_phase = (ctl_q.st == ST_HDR);
        // the next accepted word would end exactly on the length limit
        at_limit  = &ctl_q.off[LEN_LOG2-1:2];
        wait_met  = ctl_q.wait_xfer ? (int'(xfer_cnt) <= int'(ctl_q.wait_lvl))
                                    : (int'(run_cnt)  <= int'(ctl_q.wait_lvl));
    end

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.op_valid = 1'b0;
        wr_en          = 1'b0;
        wr_xfer        = 1'b0;
        wr_idx         = '0;
        wr_data        = '0;
        run_inc        = 1'b0;
        xfer_inc       = 1'b0;
        case (ctl_q.st)
            ST_HDR: if (in_valid) begin
                if (at_limit) begin
                    ctl_d.st       = ST_ERR;
                    ctl_d.err_kind = ERR_LEN;
                    ctl_d.err_off  = ctl_q.off;
                end else begin
                    ctl_d.off      = ctl_q.off + LEN_LOG2'(4);
                    ctl_d.hdr_off  = ctl_q.off;
                    ctl_d.hdr_prm  = in_data[31:16];
                    ctl_d.hdr_xfer = dec_xfer;
                    ctl_d.hdr_slot = dec_slot;
                    case (dec_kind)
                        K_STOP: ctl_d.st = ST_STOP;
                        K_RUN, K_XFER: begin
                            ctl_d.op_valid = 1'b1;
                            ctl_d.op_xfer  = (dec_kind == K_XFER);
                            ctl_d.op_code  = in_data[OPC_W-1:0];
                            ctl_d.op_param = in_data[31:16];
                            run_inc        = (dec_kind == K_RUN);
                            xfer_inc       = (dec_kind == K_XFER);
                        end
                        K_WAIT_RUN, K_WAIT_XFER: begin
                            ctl_d.st        = ST_WAIT;
                            ctl_d.wait_xfer = (dec_kind == K_WAIT_XFER);
                            ctl_d.wait_lvl  = in_data[16 +: LVL_W];
                        end
                        K_CFG_SHORT: begin
                            wr_en   = 1'b1;
                            wr_xfer = dec_xfer;
                            wr_idx  = dec_slot;
                            wr_data = REG_W'(in_data[31:16]);
                        end
                        K_CFG_LONG: ctl_d.st = ST_PAY;
                        K_BAD_MODE: begin
                            ctl_d.st       = ST_ERR;
                            ctl_d.err_kind = ERR_MODE;
                            ctl_d.err_off  = ctl_q.off;
                        end
                        default: begin
                            ctl_d.st       = ST_ERR;
                            ctl_d.err_kind = ERR_OPC;
                            ctl_d.err_off  = ctl_q.off;
                        end
                    endcase
                end
            end
            ST_PAY: if (in_valid) begin
                if (at_limit) begin
                    ctl_d.st       = ST_ERR;
                    ctl_d.err_kind = ERR_LEN;
                    ctl_d.err_off  = ctl_q.hdr_off;
                end else begin
                    ctl_d.off = ctl_q.off + LEN_LOG2'(4);
                    ctl_d.st  = ST_HDR;
                    wr_en     = 1'b1;
                    wr_xfer   = ctl_q.hdr_xfer;
                    wr_idx    = ctl_q.hdr_slot;
                    wr_data   = {ctl_q.hdr_prm, in_data};
                end
            end
            ST_WAIT: if (wait_met) ctl_d.st = ST_HDR;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign in_ready     = hdr_phase || (ctl_q.st == ST_PAY);
    assign op_valid     = ctl_q.op_valid;
    assign op_xfer      = ctl_q.op_xfer;
    assign op_code      = ctl_q.op_code;
    assign op_param     = ctl_q.op_param;
    assign run_pending  = run_cnt;
    assign xfer_pending = xfer_cnt;
    assign rd_data      = bank_rd[rd_xfer];
    assign done         = (ctl_q.st == ST_STOP);
    assign err          = (ctl_q.st == ST_ERR);
    assign err_kind     = ctl_q.err_kind;
    assign err_off      = ctl_q.err_off;
endmodule

// File: rtl/cmdp_checker.sv
module cmdp_checker
    import cmdp_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int LEN_LOG2 = 24
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [31:0]         in_data,
    input logic                in_ready,
    input logic                hdr_phase,
    input logic                run_done,
    input logic                op_valid,
    input logic                op_xfer,
    input logic [15:0]         op_param,
    input logic [CNT_W-1:0]    run_pending,
    input logic                done,
    input logic                err,
    input logic [1:0]          err_kind,
    input logic [LEN_LOG2-1:0] err_off
);
    logic hdr_take, is_short;
    assign hdr_take = in_valid && hdr_phase;
    assign is_short = (in_data[15:14] == MODE_SHORT);

    p_wait_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_take && is_short &&
         (in_data[9:0] == OPC_WAIT_RUN || in_data[9:0] == OPC_WAIT_XFER)) |=> !in_ready);

    p_stop_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && !in_ready));

    p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (err && $stable(err_off) && $stable(err_kind)));

    p_bad_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_take && in_data[15]) |=> err);

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!in_ready && !done));

    p_pend_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_pending == '0 && run_done) |=> (run_pending == '0 || (op_valid && !op_xfer)));

    p_run_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_take && is_short && in_data[9:0] == OPC_RUN) |=>
        ((op_valid && !op_xfer && op_param == $past(in_data[31:16])) || err));

    p_long_payload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_take && in_data[15:14] == MODE_LONG) |=> (in_ready || err));
endmodule

bind cmdp_parser cmdp_checker #(.CNT_W(CNT_W), .LEN_LOG2(LEN_LOG2)) i_cmdp_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ready    (in_ready),
    .hdr_phase   (hdr_phase),
    .run_done    (run_done),
    .op_valid    (op_valid),
    .op_xfer     (op_xfer),
    .op_param    (op_param),
    .run_pending (run_pending),
    .done        (done),
    .err         (err),
    .err_kind    (err_kind),
    .err_off     (err_off)
);

// File: tb/test_cmdp_parser.sv
`timescale 1ns/1ps
module test_cmdp_parser;
    localparam int NREG     = 8;
    localparam int CNT_W    = 4;
    localparam int LEN_LOG2 = 8;
    localparam int IDX_W    = $clog2(NREG);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [31:0]         in_data = '0;
    logic                in_ready;
    logic                run_done = 1'b0;
    logic                xfer_done = 1'b0;
    logic                op_valid, op_xfer;
    logic [9:0]          op_code;
    logic [15:0]         op_param;
    logic [CNT_W-1:0]    run_pending, xfer_pending;
    logic                rd_xfer = 1'b0;
    logic [IDX_W-1:0]    rd_idx = '0;
    logic [47:0]         rd_data;
    logic                done, err;
    logic [1:0]          err_kind;
    logic [LEN_LOG2-1:0] err_off;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    cmdp_parser #(.NREG(NREG), .CNT_W(CNT_W), .LEN_LOG2(LEN_LOG2)) i_cmdp_parser (
        .clk, .rst_n, .in_valid, .in_data, .in_ready, .run_done, .xfer_done,
        .op_valid, .op_xfer, .op_code, .op_param, .run_pending, .xfer_pending,
        .rd_xfer, .rd_idx, .rd_data, .done, .err, .err_kind, .err_off
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        in_valid = 1'b0; run_done = 1'b0; xfer_done = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic send(input logic [31:0] w);
        in_valid = 1'b1; in_data = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic read_reg(input logic bank, input int idx, output logic [47:0] v);
        rd_xfer = bank; rd_idx = IDX_W'(idx);
        #1 v = rd_data;
    endtask

    task automatic t_reset();
        logic [47:0] v;
        do_reset();
        check("R11", "in_ready", 64'(in_ready), 64'd1);
        check("R11", "done/err/op_valid", {61'd0, done, err, op_valid}, 64'd0);
        check("R11", "pending", {56'd0, run_pending, xfer_pending}, 64'd0);
        read_reg(1'b0, 3, v); check("R11", "compute reg3", 64'(v), 64'd0);
        read_reg(1'b1, 7, v); check("R11", "transfer reg7", 64'(v), 64'd0);
    endtask

    task automatic t_cfg_short();
        logic [47:0] v;
        do_reset();
        send(32'hABCD_0103);
        read_reg(1'b0, 3, v); check("R2", "compute reg3", 64'(v), 64'h0000_0000_ABCD);
        read_reg(1'b1, 3, v); check("R2", "transfer reg3 untouched", 64'(v), 64'd0);
        send(32'h1234_0185);
        read_reg(1'b1, 5, v); check("R2", "transfer reg5", 64'(v), 64'h0000_0000_1234);
        read_reg(1'b0, 5, v); check("R2", "compute reg5 untouched", 64'(v), 64'd0);
    endtask

    task automatic t_cfg_long();
        logic [47:0] v;
        do_reset();
        send(32'h00EE_4102);
        check("R3", "ready before payload", 64'(in_ready), 64'd1);
        send(32'hDEAD_BEEF);
        read_reg(1'b0, 2, v); check("R3", "compute reg2", 64'(v), 64'h00EE_DEAD_BEEF);
        send(32'h0001_4181);
        send(32'h0000_0010);
        read_reg(1'b1, 1, v); check("R1", "transfer reg1 long form", 64'(v), 64'h0001_0000_0010);
    endtask

    task automatic t_ops();
        do_reset();
        send(32'h0055_0001);
        check("R4", "run pulse", {44'd0, op_valid, op_xfer, op_code, op_param},
              {44'd0, 1'b1, 1'b0, 10'h001, 16'h0055});
        check("R4", "run pending", 64'(run_pending), 64'd1);
        @(negedge clk);
        check("R4", "pulse one cycle", 64'(op_valid), 64'd0);
        send(32'h0023_0002);
        check("R1", "xfer pulse fields", {44'd0, op_valid, op_xfer, op_code, op_param},
              {44'd0, 1'b1, 1'b1, 10'h002, 16'h0023});
        check("R4", "xfer pending", {56'd0, run_pending, xfer_pending}, {56'd0, 4'd1, 4'd1});
    endtask

    task automatic t_counters();
        do_reset();
        repeat (3) send(32'h0000_0001);
        check("R5", "three starts", 64'(run_pending), 64'd3);
        repeat (2) begin run_done = 1'b1; @(negedge clk); end
        run_done = 1'b0;
        check("R5", "two dones", 64'(run_pending), 64'd1);
        repeat (3) begin run_done = 1'b1; @(negedge clk); end
        run_done = 1'b0;
        check("R5", "floor at zero", 64'(run_pending), 64'd0);
        send(32'h0000_0001);
        run_done = 1'b1;
        send(32'h0000_0001);
        run_done = 1'b0;
        check("R5", "start with done", 64'(run_pending), 64'd1);
    endtask

    task automatic t_wait();
        do_reset();
        repeat (2) send(32'h0000_0001);
        send(32'h0011_0003);      // channel 1, level 1
        check("R6", "stall starts", 64'(in_ready), 64'd0);
        repeat (3) @(negedge clk);
        check("R6", "stall while above level", 64'(in_ready), 64'd0);
        run_done = 1'b1; @(negedge clk); run_done = 1'b0;
        check("R6", "still stalled on done edge", 64'(in_ready), 64'd0);
        @(negedge clk);
        check("R6", "release", 64'(in_ready), 64'd1);
        send(32'h0000_0004);      // transfer count 0, level 0, compute still 1
        check("R6", "transfer wait bubble", 64'(in_ready), 64'd0);
        @(negedge clk);
        check("R6", "transfer wait ignores compute", 64'(in_ready), 64'd1);
    endtask

    task automatic t_stop();
        logic [47:0] v;
        do_reset();
        send(32'hFFFF_0000);
        check("R7", "done", {62'd0, done, in_ready}, 64'd2);
        in_valid = 1'b1; in_data = 32'h5555_0101;
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        read_reg(1'b0, 1, v); check("R7", "write after stop ignored", 64'(v), 64'd0);
        check("R7", "still done", {62'd0, done, err}, 64'd2);
        do_reset();
        send(32'h0001_0000);
        check("R9", "stop with wrong param", {61'd0, err, err_kind}, {61'd0, 1'b1, 2'd2});
    endtask

    task automatic t_bad_mode();
        do_reset();
        send(32'h0001_0100);
        send(32'h0002_0101);
        send(32'h0000_8101);
        check("R8", "mode 10 error", {61'd0, err, err_kind}, {61'd0, 1'b1, 2'd1});
        check("R8", "offset", 64'(err_off), 64'd8);
        check("R8", "halted", 64'(in_ready), 64'd0);
        repeat (2) @(negedge clk);
        check("R8", "sticky", {53'd0, err, err_kind, err_off}, {53'd0, 1'b1, 2'd1, 8'd8});
        do_reset();
        send(32'h0000_C101);
        check("R8", "mode 11 error", {53'd0, err, err_kind, err_off}, {53'd0, 1'b1, 2'd1, 8'd0});
    endtask

    task automatic t_bad_opc();
        do_reset();
        send(32'h0000_0100);
        send(32'h0000_0007);
        check("R9", "unknown short", {53'd0, err, err_kind, err_off}, {53'd0, 1'b1, 2'd2, 8'd4});
        do_reset();
        send(32'h0000_4001);
        check("R9", "unknown long", {61'd0, err, err_kind}, {61'd0, 1'b1, 2'd2});
        do_reset();
        send(32'h0000_0108);
        check("R9", "index past NREG", {61'd0, err, err_kind}, {61'd0, 1'b1, 2'd2});
    endtask

    task automatic t_length();
        logic [47:0] v;
        do_reset();
        for (int i = 0; i < 63; i++) send({16'(i), 16'h0100});
        check("R10", "no error below limit", 64'(err), 64'd0);
        send(32'h7777_0100);
        check("R10", "short at limit", {53'd0, err, err_kind, err_off}, {53'd0, 1'b1, 2'd3, 8'd252});
        read_reg(1'b0, 0, v); check("R10", "word dropped", 64'(v), 64'd62);
        do_reset();
        for (int i = 0; i < 62; i++) send({16'(i), 16'h0100});
        send(32'h0009_4100);
        send(32'h1111_1111);
        check("R10", "payload at limit", {53'd0, err, err_kind, err_off}, {53'd0, 1'b1, 2'd3, 8'd248});
        read_reg(1'b0, 0, v); check("R10", "payload dropped", 64'(v), 64'd61);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_cfg_short();
        t_cfg_long();
        t_ops();
        t_counters();
        t_wait();
        t_stop();
        t_bad_mode();
        t_bad_opc();
        t_length();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule